// File: doc/BRIEF.md
# Serial identifier responder

This block answers a one-bit request by sending a fixed 4-bit identifier on a single serial line. While no request is pending it waits and holds the line low. When it samples the request high on a clock edge, it steps through four dedicated transmit states, one per clock. Each state drives one identifier bit, most significant bit first. After the last bit it goes back to waiting. A request that arrives during a transmission is ignored.

The block is a Moore machine: the serial output is decoded from the current state alone, so the request input has no combinational path to it. The identifier is a parameter, and its default is binary 1101. Reset is asynchronous and active low. It takes effect at once and is released through a two-stage synchronizer.

Top module: `sid_responder`

## Requirements
- R1: When `rst_n` is driven low, `id_out` goes to 0 at once and the machine enters the waiting state. After `rst_n` rises, the machine stays in reset for two rising clock edges, and requests sampled on those two edges are ignored.
- R2: In the waiting state `id_out` is 0. The machine stays in the waiting state on every edge where `id_req` is 0.
- R3: If `id_req` is 1 on a rising edge while the machine is waiting, `id_out` shows identifier bit 3 in the cycle that follows that edge.
- R4: The four identifier bits appear in the order bit 3, bit 2, bit 1, bit 0, one per cycle, each for exactly one cycle. With the default identifier 4'b1101 the line carries 1, 1, 0, 1.
- R5: After the cycle that shows bit 0, the machine returns to waiting and `id_out` is 0 for at least one cycle. A request that is held at 1 starts a new frame from bit 3 on the edge that follows that idle cycle.
- R6: A value of `id_req` sampled during the four transmit cycles does not restart, extend or shorten the frame.
- R7: `id_out` changes only after a rising clock edge (or on reset). A change of `id_req` between edges leaves `id_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_req | input | 1 | Request for the identifier, sampled on the rising edge |
| id_out | output | 1 | Serial identifier line, MSB first, 0 when idle |

## Verification
A wrong internal state shows at `id_out` in the cycle right after the faulty edge. A missed request shows as a 0 where bit 3 was due. A skipped or repeated state shows as a bit out of place within the 1-1-0-1 pattern. A restart caused by a mid-frame request shows as a frame that is too long. A missing return to idle shows as a missing 0 between frames that are held back to back. The scoreboard therefore compares every cycle. It also samples a second time after `id_req` has changed between edges, which exposes any path from the request to the output.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int unsigned SID_BITS = 4;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_B3   = 3'd1,
    ST_B2   = 3'd2,
    ST_B1   = 3'd3,
    ST_B0   = 3'd4
  } sid_state_e;
endpackage

// File: rtl/sid_rst_sync.sv
module sid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sid_fsm.sv
module sid_fsm
  import sid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  output sid_state_e state_o
);
  sid_state_e state_q, state_d;
  logic       state_en;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: state_d = req_i ? ST_B3 : ST_WAIT;
      ST_B3:   state_d = ST_B2;
      ST_B2:   state_d = ST_B1;
      ST_B1:   state_d = ST_B0;
      ST_B0:   state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  // Only the waiting state with no request holds still
  assign state_en = (state_q != ST_WAIT) || req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_WAIT;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !req_i) |=> (state_q == ST_WAIT));
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && req_i) |=> (state_q == ST_B3));
  p_order_b3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B3) |=> (state_q == ST_B2));
  p_order_b2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B2) |=> (state_q == ST_B1));
  p_order_b1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B1) |=> (state_q == ST_B0));
  p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_B0) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/sid_out_decode.sv
module sid_out_decode
  import sid_pkg::*;
#(
  parameter logic [SID_BITS-1:0] ID_VALUE = 4'b1101
) (
  input  sid_state_e state_i,
  output logic       bit_o
);
  always_comb begin
    unique case (state_i)
      ST_B3:   bit_o = ID_VALUE[3];
      ST_B2:   bit_o = ID_VALUE[2];
      ST_B1:   bit_o = ID_VALUE[1];
      ST_B0:   bit_o = ID_VALUE[0];
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sid_responder.sv
module sid_responder
  import sid_pkg::*;
#(
  parameter logic [SID_BITS-1:0] ID_VALUE   = 4'b1101,
  parameter int unsigned         SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic id_req,
  output logic id_out
);
  logic       rst_core_n;
  sid_state_e state;

  sid_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sid_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req_i   (id_req),
    .state_o (state)
  );

  sid_out_decode #(.ID_VALUE(ID_VALUE)) u_dec (
    .state_i (state),
    .bit_o   (id_out)
  );

  p_wait_low_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_WAIT) |-> (id_out == 1'b0));
  p_moore_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == $past(state)) |-> (id_out == $past(id_out)));
  p_reset_low_r1: assert property (@(posedge clk)
    (!rst_core_n) |-> (id_out == 1'b0));
endmodule

// File: tb/sid_responder_tb.sv
`timescale 1ns/1ps
module sid_responder_tb;
  localparam logic [3:0] ID = 4'b1101;

  logic clk = 1'b0;
  logic rst_n;
  logic id_req;
  logic id_out;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sid_responder u_dut (.clk(clk), .rst_n(rst_n), .id_req(id_req), .id_out(id_out));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: id_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: set the request and push the output expected after the next edge
  task automatic step(input bit r, input string tag);
    int nxt;
    @(negedge clk);
    id_req = r;
    if (m_cnt == 0) nxt = r ? 1 : 0;
    else            nxt = (m_cnt == 4) ? 0 : m_cnt + 1;
    m_cnt = nxt;
    exp_q.push_back(nxt == 0 ? 1'b0 : ID[4-nxt]);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after each edge, again after the request may have moved
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, id_out, e);
        #2;
        check("R7", id_out, e);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    id_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", id_out, 1'b0);
    rst_n  = 1'b1;
    id_req = 1'b1;                 // ignored while reset is synchronised
    @(posedge clk); #1 check("R1", id_out, 1'b0);
    @(posedge clk); #1 check("R1", id_out, 1'b0);
    @(negedge clk); id_req = 1'b0;
    @(posedge clk); #1 check("R1", id_out, 1'b0);

    // idle with no request
    for (int i = 0; i < 3; i++) step(1'b0, "R2");
    // single pulse then one full frame
    step(1'b1, "R3");
    for (int i = 0; i < 6; i++) step(1'b0, "R4");
    // held request: back-to-back frames with one idle cycle between
    for (int i = 0; i < 12; i++) step(1'b1, "R5");
    for (int i = 0; i < 3; i++) step(1'b0, "R5");
    // requests during transmission are ignored
    step(1'b1, "R3");
    step(1'b1, "R6");
    step(1'b0, "R6");
    step(1'b1, "R6");
    step(1'b1, "R6");
    step(1'b0, "R5");
    step(1'b0, "R2");
    // mid-frame asynchronous reset
    step(1'b1, "R3");
    step(1'b0, "R4");
    step(1'b0, "R4");
    @(posedge clk); #2;
    @(negedge clk); #1;
    check("R4", id_out, ID[1]);
    rst_n = 1'b0;
    #0.5;
    check("R1", id_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", id_out, 1'b0);
    m_cnt = 0;
    step(1'b1, "R3");
    for (int i = 0; i < 5; i++) step(1'b0, "R4");
    @(posedge clk); #4;
    finish_run();
  end
endmodule